// File: doc/BRIEF.md
# ADC Input Conditioning Stage

This block sits directly behind the converter on one channel of a bunch-by-bunch signal chain. Each clock it may receive one signed 14-bit sample, marked by a valid strobe. It does two jobs on that stream. It compares the magnitude of every accepted sample with a threshold set by software and reports a crossing. It also runs the stream through an eight-tap compensation FIR with programmable coefficients. The FIR result is scaled back to integer units and clamped, never wrapped, to a 16-bit signed output.

Software reaches the block through a plain write port: enable, address and data. Coefficients are written into a staging bank and go live only after an explicit commit. A two-state controller, `COEF_LIVE` and `COEF_ARMED`, moves the staged set into the working set at a sample boundary. Two sticky flags record that something happened since they were last cleared. One flag covers an input threshold crossing and the other covers clamping at the FIR output. Each flag is cleared by its own bit in a clear write.

Controller transitions: `COEF_LIVE` goes to `COEF_ARMED` on a commit write. `COEF_ARMED` copies the staged bank into the working bank on the next accepted sample and then returns to `COEF_LIVE`. If that cycle also carries a commit write, it stays in `COEF_ARMED`. A commit while already armed keeps it armed.

Top module: `adc_cond_stage`

## Requirements
- R1: While `rst` is high and after it falls, `out_valid`, `out_data`, `ovf_evt`, `ovf_flag` and `sat_flag` are all zero until a sample is accepted. After reset the working coefficients are all zero, the sample history is all zero and the threshold is 16383.
- R2: `out_valid` is high in cycle t+4 exactly when `in_valid` was high in cycle t. Gaps in the input stream are reproduced unchanged at the output.
- R3: For the n-th accepted sample, `out_data` = clamp16(floor((sum over k=0..7 of c[k]·x[n-k]) / 2^17)). c[k] is the signed 18-bit working coefficient of tap k. x[n-k] is the sample accepted k samples earlier, taken as zero before any sample.
- R4: When the scaled sum is above 32767, the output is 32767. When it is below -32768, the output is -32768. `sat_flag` rises in the same cycle as that clamped output.
- R5: A sample accepted in cycle t with |x| ≥ threshold raises `ovf_evt` for exactly cycle t+1. A write at address 8 sets the threshold to unsigned `reg_wdata[13:0]`. The new threshold applies to samples accepted after the write cycle.
- R6: `ovf_flag` and `sat_flag` stay set until a write at address 10 clears them: `reg_wdata[0]` clears `ovf_flag` and `reg_wdata[1]` clears `sat_flag`. If a new event arrives in the same cycle as the clear, the flag stays set.
- R7: A write at address k (0..7) stores tap k in the staging bank only. Outputs keep using the previous working set until a commit, which is a write at address 9.
- R8: After a commit write in cycle t, every sample accepted before or in cycle t uses the old set in full. Every sample accepted after cycle t uses the full new set, so no output mixes the two sets.
- R9: Writes at addresses 11 to 15 change neither the outputs nor any setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present on `in_data` |
| in_data | input | 14 | Signed ADC sample |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0-7 taps, 8 threshold, 9 commit, 10 clear) |
| reg_wdata | input | 18 | Register write data |
| ovf_evt | output | 1 | One-cycle threshold crossing pulse |
| ovf_flag | output | 1 | Sticky input threshold crossing flag |
| out_valid | output | 1 | Filtered sample present on `out_data` |
| out_data | output | 16 | Signed, clamped FIR output |
| sat_flag | output | 1 | Sticky output clamp flag |

## Verification
The hardest case to reach from the ports is a commit that lands on the same cycle as an accepted sample while older samples are still inside the pipeline. In that case the working bank changes between product stages of neighbouring samples. The bench drives this case directly. It writes new taps without committing and checks that the old response persists. It then issues the commit together with a valid sample and keeps streaming, so that outputs on both sides of the switch are compared against a model that swaps banks only on the first later sample. Clamping in both directions is reached by committing near-unity coefficients on every tap and feeding full-scale inputs of each sign. A long random run mixes stream gaps with writes to every address.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;
    localparam int ADC_W     = 14;
    localparam int COEF_W    = 18;
    localparam int COEF_FRAC = 17;
    localparam int OUT_W     = 16;
    localparam int N_TAPS    = 8;
    localparam int ADDR_W    = 4;

    localparam int THR_ADDR    = N_TAPS;
    localparam int COMMIT_ADDR = N_TAPS + 1;
    localparam int CLEAR_ADDR  = N_TAPS + 2;

    typedef enum logic {
        COEF_LIVE,
        COEF_ARMED
    } coef_state_e;
endpackage

// File: rtl/adc_ovf_detect.sv
module adc_ovf_detect #(
    parameter int IN_W = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    input  logic            thr_we,
    input  logic [IN_W-1:0] thr_wdata,
    input  logic            clr,
    output logic            evt,
    output logic            flag
);
    logic [IN_W-1:0] thr_q;
    logic [IN_W-1:0] mag;
    logic            hit;

    // Magnitude as unsigned; the most negative code maps to 2^(IN_W-1).
    always_comb begin
        mag = in_data[IN_W-1] ? (~in_data + 1'b1) : in_data;
        hit = in_valid && (mag >= thr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '1;
            evt   <= 1'b0;
            flag  <= 1'b0;
        end else begin
            if (thr_we) thr_q <= thr_wdata;
            evt  <= hit;
            flag <= hit | (flag & ~clr);
        end
    end
endmodule

// File: rtl/adc_coef_bank.sv
module adc_coef_bank
    import adc_cond_pkg::*;
#(
    parameter int TAPS   = 8,
    parameter int CW     = 18,
    parameter int AW     = 4,
    parameter int COMMIT = TAPS + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [CW-1:0]    reg_wdata,
    input  logic             in_valid,
    output logic [TAPS*CW-1:0] coef_act
);
    coef_state_e     state_q, state_d;
    logic            load_now;
    logic            commit_wr;
    logic [CW-1:0]   shadow [TAPS];

    assign commit_wr = reg_we && (reg_addr == AW'(COMMIT));

    always_ff @(posedge clk) begin
        if (rst) state_q <= COEF_LIVE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load_now = 1'b0;
        unique case (state_q)
            COEF_LIVE: begin
                if (commit_wr) state_d = COEF_ARMED;
            end
            COEF_ARMED: begin
                load_now = in_valid;
                if (commit_wr)     state_d = COEF_ARMED;
                else if (in_valid) state_d = COEF_LIVE;
            end
            default: state_d = COEF_LIVE;
        endcase
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[k]              <= '0;
                coef_act[k*CW +: CW]   <= '0;
            end else begin
                if (load_now)
                    coef_act[k*CW +: CW] <= shadow[k];
                if (reg_we && (reg_addr == AW'(k)))
                    shadow[k] <= reg_wdata;
            end
        end
    end
endmodule

// File: rtl/adc_fir_core.sv
module adc_fir_core #(
    parameter int IN_W = 14,
    parameter int CW   = 18,
    parameter int FRAC = 17,
    parameter int OW   = 16,
    parameter int TAPS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [IN_W-1:0]        in_data,
    input  logic [TAPS*CW-1:0]     coef_act,
    input  logic                   clr_sat,
    output logic                   out_valid,
    output logic [OW-1:0]          out_data,
    output logic                   sat_flag
);
    localparam int PROD_W = IN_W + CW;
    localparam int ACC_W  = PROD_W + $clog2(TAPS);
    localparam int SH_W   = ACC_W - FRAC;
    localparam logic signed [SH_W-1:0] MAX_S = {{(SH_W-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [SH_W-1:0] MIN_S = {{(SH_W-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic signed [IN_W-1:0]   line [TAPS];
    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [ACC_W-1:0]  acc_q, acc_sum;
    logic signed [ACC_W-1:0]  acc_sh;
    logic signed [SH_W-1:0]   scaled;
    logic                     v1, v2, v3;
    logic                     clip_hi, clip_lo;

    // Stage 1: sample history, shifted once per accepted sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            for (int k = 0; k < TAPS; k++) line[k] <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                line[0] <= in_data;
                for (int k = 1; k < TAPS; k++) line[k] <= line[k-1];
            end
        end
    end

    // Stage 2: all products formed in one cycle from one working bank.
    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        always_ff @(posedge clk) begin
            if (rst) prod[k] <= '0;
            else     prod[k] <= PROD_W'(line[k]) * PROD_W'($signed(coef_act[k*CW +: CW]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) v2 <= 1'b0;
        else     v2 <= v1;
    end

    // Stage 3: full-precision sum.
    always_comb begin
        acc_sum = '0;
        for (int k = 0; k < TAPS; k++)
            acc_sum = acc_sum + {{(ACC_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            v3    <= 1'b0;
        end else begin
            acc_q <= acc_sum;
            v3    <= v2;
        end
    end

    // Stage 4: scale, clamp, register.
    always_comb begin
        acc_sh  = acc_q >>> FRAC;
        scaled  = acc_sh[SH_W-1:0];
        clip_hi = scaled > MAX_S;
        clip_lo = scaled < MIN_S;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= v3;
            if (v3) begin
                if (clip_hi)      out_data <= MAX_S[OW-1:0];
                else if (clip_lo) out_data <= MIN_S[OW-1:0];
                else              out_data <= scaled[OW-1:0];
            end
            sat_flag <= (v3 & (clip_hi | clip_lo)) | (sat_flag & ~clr_sat);
        end
    end
endmodule

// File: rtl/adc_cond_stage.sv
module adc_cond_stage
    import adc_cond_pkg::*;
#(
    parameter int IN_W = ADC_W,
    parameter int CW   = COEF_W,
    parameter int FRAC = COEF_FRAC,
    parameter int OW   = OUT_W,
    parameter int TAPS = N_TAPS,
    parameter int AW   = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [CW-1:0]   reg_wdata,
    output logic            ovf_evt,
    output logic            ovf_flag,
    output logic            out_valid,
    output logic [OW-1:0]   out_data,
    output logic            sat_flag
);
    localparam int A_THR = TAPS;
    localparam int A_COM = TAPS + 1;
    localparam int A_CLR = TAPS + 2;

    logic               thr_we, clr_hit;
    logic [TAPS*CW-1:0] coef_act;

    assign thr_we  = reg_we && (reg_addr == AW'(A_THR));
    assign clr_hit = reg_we && (reg_addr == AW'(A_CLR));

    adc_ovf_detect #(.IN_W(IN_W)) u_ovf (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .thr_we    (thr_we),
        .thr_wdata (reg_wdata[IN_W-1:0]),
        .clr       (clr_hit & reg_wdata[0]),
        .evt       (ovf_evt),
        .flag      (ovf_flag)
    );

    adc_coef_bank #(.TAPS(TAPS), .CW(CW), .AW(AW), .COMMIT(A_COM)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .in_valid  (in_valid),
        .coef_act  (coef_act)
    );

    adc_fir_core #(.IN_W(IN_W), .CW(CW), .FRAC(FRAC), .OW(OW), .TAPS(TAPS)) u_fir (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .coef_act  (coef_act),
        .clr_sat   (clr_hit & reg_wdata[1]),
        .out_valid (out_valid),
        .out_data  (out_data),
        .sat_flag  (sat_flag)
    );
endmodule

// File: rtl/adc_cond_checks.sv
module adc_cond_checks #(
    parameter int OW    = 16,
    parameter int AW    = 4,
    parameter int CW    = 18,
    parameter int A_CLR = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [CW-1:0] reg_wdata,
    input logic          ovf_evt,
    input logic          ovf_flag,
    input logic          out_valid,
    input logic [OW-1:0] out_data,
    input logic          sat_flag
);
    localparam logic [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
    localparam logic [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

    logic clr_ovf;
    assign clr_ovf = reg_we && (reg_addr == AW'(A_CLR)) && reg_wdata[0];

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##4 out_valid);

    assert_no_phantom_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 4));

    assert_evt_source_R5: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |-> $past(in_valid));

    assert_ovf_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> ovf_evt);

    assert_ovf_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    assert_sat_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flag) |-> (out_valid && (out_data == MAXV || out_data == MINV)));
endmodule

bind adc_cond_stage adc_cond_checks #(
    .OW(OW), .AW(AW), .CW(CW), .A_CLR(TAPS + 2)
) u_checks (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ovf_evt   (ovf_evt),
    .ovf_flag  (ovf_flag),
    .out_valid (out_valid),
    .out_data  (out_data),
    .sat_flag  (sat_flag)
);

// File: tb/sim_adc_cond_stage.sv
module sim_adc_cond_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [13:0] in_data = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [17:0] reg_wdata = '0;
    logic        ovf_evt, ovf_flag, out_valid, sat_flag;
    logic [15:0] out_data;

    always #5 clk = ~clk;

    adc_cond_stage u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ovf_evt(ovf_evt), .ovf_flag(ovf_flag), .out_valid(out_valid),
        .out_data(out_data), .sat_flag(sat_flag)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    string phase = "";
    int    cyc = 0;

    // reference model state
    int    act [8];
    int    shd [8];
    int    hist [8];
    int    thr = 16383;
    bit    pend = 0;
    bit    ev [8];
    int    ed [8];
    bit    es [8];
    bit    evt_next = 0;
    bit    m_ovf = 0, m_sat = 0;
    bit    clr_o_prev = 0, clr_s_prev = 0;

    task automatic chk(input string tag, input longint act_v, input longint exp_v);
        n_vec++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s cycle %0d: got %0d expected %0d", tag, cyc, act_v, exp_v);
        end
    endtask

    function automatic int model_y(output bit clipped);
        longint acc = 0;
        for (int k = 0; k < 8; k++) acc += longint'(act[k]) * longint'(hist[k]);
        acc = acc >>> 17;
        clipped = 1'b0;
        if (acc > 32767)  begin acc = 32767;  clipped = 1'b1; end
        if (acc < -32768) begin acc = -32768; clipped = 1'b1; end
        return int'(acc);
    endfunction

    task automatic step(input bit v, input int x, input bit we, input int a, input int d);
        int  s;
        int  mag;
        int  ns;
        bit  clp;
        @(negedge clk);
        s = cyc % 8;
        m_ovf = (m_ovf && !clr_o_prev) || evt_next;
        m_sat = (m_sat && !clr_s_prev) || (ev[s] && es[s]);
        chk("R2 out_valid", out_valid, ev[s]);
        if (ev[s])
            chk(phase != "" ? phase : (es[s] ? "R4 clamp" : "R3 fir"),
                longint'($signed(out_data)), ed[s]);
        chk("R5 ovf_evt", ovf_evt, evt_next);
        chk("R6 ovf_flag", ovf_flag, m_ovf);
        chk("R4/R6 sat_flag", sat_flag, m_sat);
        ev[s] = 1'b0;
        // model update for inputs driven this cycle
        x   = int'($signed(14'(x)));
        mag = (x < 0) ? -x : x;
        evt_next = v && (mag >= thr);
        if (v) begin
            if (pend) begin act = shd; pend = 0; end
            for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = x;
            ns = (cyc + 4) % 8;
            ed[ns] = model_y(clp);
            es[ns] = clp;
            ev[ns] = 1'b1;
        end
        clr_o_prev = 0; clr_s_prev = 0;
        if (we) begin
            if (a < 8)        shd[a] = int'($signed(18'(d)));
            else if (a == 8)  thr = d & 16'h3FFF;
            else if (a == 9)  pend = 1;
            else if (a == 10) begin clr_o_prev = d[0]; clr_s_prev = d[1]; end
        end
        in_valid  = v;
        in_data   = 14'(x);
        reg_we    = we;
        reg_addr  = 4'(a);
        reg_wdata = 18'(d);
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic wr(input int a, input int d);
        step(0, 0, 1, a, d);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int k = 0; k < 8; k++) begin act[k] = 0; shd[k] = 0; hist[k] = 0; ev[k] = 0; ed[k] = 0; es[k] = 0; end
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_data", out_data, 0);
        chk("R1 ovf_evt", ovf_evt, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R1 sat_flag", sat_flag, 0);
        rst = 1'b0;
        // R1: zero coefficients give zero output
        phase = "R1 zero coef";
        step(1, 5000, 0, 0, 0); step(1, -3000, 0, 0, 0);
        idle(5);
        // R3: basic response
        phase = "";
        wr(0, 65536); wr(1, -32768); wr(2, 20000); wr(7, 131071); wr(9, 0);
        for (int i = 0; i < 12; i++) step(1, (i * 1237) % 8000 - 4000, 0, 0, 0);
        step(0, 0, 0, 0, 0); step(1, 8191, 0, 0, 0); step(0, 0, 0, 0, 0); step(1, -8192, 0, 0, 0);
        idle(6);
        // R7: staged writes have no effect without a commit
        phase = "R7 staged";
        wr(0, 131071); wr(1, 131071); wr(3, -100000);
        for (int i = 0; i < 8; i++) step(1, 1000 + 300 * i, 0, 0, 0);
        // R8: commit on the same cycle as a valid sample
        phase = "R8 boundary";
        step(1, 2500, 1, 9, 0);
        for (int i = 0; i < 8; i++) step(1, -700 * i, 0, 0, 0);
        step(1, 123, 1, 9, 0);
        step(1, 456, 1, 5, 7777);
        step(1, 789, 0, 0, 0);
        idle(6);
        // R9: unused addresses
        phase = "R9 unused";
        for (int a = 11; a < 16; a++) step(1, 3000 - a * 100, 1, a, 18'h3FFFF);
        idle(6);
        // R4: clamp both directions
        phase = "";
        for (int k = 0; k < 8; k++) wr(k, 131071);
        wr(9, 0);
        for (int i = 0; i < 10; i++) step(1, 8191, 0, 0, 0);
        for (int i = 0; i < 10; i++) step(1, -8192, 0, 0, 0);
        idle(6);
        wr(10, 2);                      // R6: clear sat only
        idle(3);
        // R5: threshold edges
        wr(8, 100);
        step(1, 99, 0, 0, 0); step(1, 100, 0, 0, 0); step(1, -100, 0, 0, 0);
        step(1, -99, 0, 0, 0); step(1, -8192, 0, 0, 0);
        idle(3);
        wr(10, 1);
        step(1, 8191, 1, 10, 1);        // R6: event wins over clear
        idle(2);
        wr(10, 3);
        wr(8, 0); step(1, 0, 0, 0, 0);  // R5: threshold 0 always fires
        wr(8, 8192); step(1, 8191, 0, 0, 0); step(1, -8192, 0, 0, 0);
        idle(6);
        // random phase
        for (int i = 0; i < 6000; i++) begin
            bit v, we;
            int a, d, x;
            v  = ($urandom() % 10) < 7;
            x  = int'($urandom() % 16384);
            we = ($urandom() % 8) == 0;
            a  = int'($urandom() % 16);
            d  = int'($urandom() % 262144);
            if (a == 10 && ($urandom() % 4) != 0) a = 9;
            step(v, x, we, a, d);
        end
        idle(8);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule